// File: doc/BRIEF.md
# Filtered-Derivative PID Step Engine

This block computes one sample of a discrete PID control law in signed Q16.16 fixed point. For each sample it accepts a setpoint, a feedback measurement, a feedforward value and a tracking value, along with four runtime coefficients: proportional, integral, derivative and derivative-filter bandwidth. It returns one saturated controller output. The derivative path is a first-order low-pass, held in an internal filter register. The integral register takes an extra correction that pulls it toward the tracking input, which gives back-calculation anti-windup when the tracking input is the actuator value after clamping.

Each sample runs on one shared rounding multiplier over four multiply phases and one final accumulate phase. The input side is a valid/ready handshake. A sample is taken on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low for the whole computation, so the upstream source must hold its data until it sees ready. The output side is a single-cycle `u_valid` strobe with no back-pressure, and `u_out` holds its value until the next result. A plain `init` control clears both internal state registers and cancels any computation in progress.

Top module: `pidf_step`

## Requirements
- R1: After reset, `in_ready` is 1, `u_valid` is 0, `u_out` is 0, and the filter and integrator registers are zero.
- R2: A sample is accepted on a rising edge where `in_valid`, `in_ready` are high and `init` is low. `in_ready` is low from the edge after acceptance until the result strobe is issued. While it is low, `in_valid` and the data inputs have no effect on the result.
- R3: `u_valid` is high for exactly one cycle. It rises on the fifth rising edge after the accepting edge, and `u_out` changes on that same edge.
- R4: Every value is signed Q16.16 in 32 bits. Each sum and difference saturates to [-2^31, 2^31-1] in raw units. Each product is the full product plus 2^15, arithmetically shifted right by 16, then saturated. With a raw input of 1, this sends +0x8000 to 1 and -0x8000 to 0.
- R5: The error is e = setpoint - feedback. The filter term is fc = (Kd·e - F)·N, where F is the filter register.
- R6: The controller sum is s = (Kp·e + I) + fc, where I is the integrator register. The output is `u_out` = feedforward + s.
- R7: At the end of a step, F becomes F + fc.
- R8: At the end of a step, I becomes ((tracking - feedforward) - s + Ki·e) + I. All terms are taken from the current step's old register values.
- R9: The output of a step depends on the filter and integrator values left by the previous completed step, so a sequence of steps accumulates state.
- R10: `init` high clears F and I on the next edge. It returns the engine to idle without a result strobe and holds `in_ready` low while it is asserted.
- R11: `u_out` keeps its value in every cycle without a result strobe, including after an aborted step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| init | input | 1 | Clear state and abort current step |
| in_valid | input | 1 | Sample data present |
| in_ready | output | 1 | Engine idle and able to take a sample |
| setpoint | input | W | Reference value, Q16.16 |
| feedback | input | W | Measured value, Q16.16 |
| feedfwd | input | W | Feedforward value added to the output |
| track | input | W | Tracking value for integrator correction |
| gain_p | input | W | Proportional coefficient |
| gain_i | input | W | Integral coefficient (sample time folded in) |
| gain_d | input | W | Derivative coefficient |
| filt_n | input | W | Derivative filter coefficient (sample time folded in) |
| u_valid | output | 1 | One-cycle result strobe |
| u_out | output | W | Controller output, Q16.16 |

## Verification
The assertions assume that `init` and `in_valid` are synchronous and that data is only sampled at the accepting edge. This lets them require a strobe that never lasts two cycles, a busy engine that never re-raises ready, and an output that never moves without a strobe. The stimulus drives every input on the falling edge. It keeps `in_valid` high with unrelated data during busy periods, asserts `init` both while idle and in the middle of a step, and mixes random operands of moderate magnitude with directed extremes that force saturation and exact rounding ties.

// File: rtl/pidf_pkg.sv
package pidf_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_DERIV = 3'd1,
    PH_FILT = 3'd2,
    PH_PROP = 3'd3,
    PH_INTG = 3'd4,
    PH_FINAL = 3'd5
  } pidf_phase_e;
endpackage

// File: rtl/pidf_mul.sv
module pidf_mul #(
  parameter int W = 32,
  parameter int FRAC = 16
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic signed [W-1:0] y
);
  localparam int PW = 2 * W;
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FRAC - 1);
  localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic signed [PW-1:0] prod, rnd, shf;
  logic fits;

  always_comb begin
    prod = $signed({{W{a[W-1]}}, a}) * $signed({{W{b[W-1]}}, b});
    rnd  = prod + HALF;
    shf  = rnd >>> FRAC;
    // in range when all bits above the result sign agree with it
    fits = (&shf[PW-1:W-1]) | ~(|shf[PW-1:W-1]);
    if (fits) y = shf[W-1:0];
    else      y = shf[PW-1] ? MINV : MAXV;
  end
endmodule

// File: rtl/pidf_seq.sv
module pidf_seq
  import pidf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        in_valid,
  output logic        in_ready,
  output logic        accept,
  output pidf_phase_e phase,
  output logic        u_valid
);
  assign in_ready = (phase == PH_IDLE) && !init;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      u_valid <= 1'b0;
    end else begin
      u_valid <= (phase == PH_FINAL) && !init;
      if (init) begin
        phase <= PH_IDLE;
      end else begin
        unique case (phase)
          PH_IDLE:  if (accept) phase <= PH_DERIV;
          PH_DERIV: phase <= PH_FILT;
          PH_FILT:  phase <= PH_PROP;
          PH_PROP:  phase <= PH_INTG;
          PH_INTG:  phase <= PH_FINAL;
          PH_FINAL: phase <= PH_IDLE;
          default:  phase <= PH_IDLE;
        endcase
      end
    end
  end

  a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    u_valid |=> !u_valid);
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);
  a_r10_init_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> !u_valid);
  a_r2_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (phase == PH_IDLE));
endmodule

// File: rtl/pidf_step.sv
module pidf_step
  import pidf_pkg::*;
#(
  parameter int W = 32,
  parameter int FRAC = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                init,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic signed [W-1:0] setpoint,
  input  logic signed [W-1:0] feedback,
  input  logic signed [W-1:0] feedfwd,
  input  logic signed [W-1:0] track,
  input  logic signed [W-1:0] gain_p,
  input  logic signed [W-1:0] gain_i,
  input  logic signed [W-1:0] gain_d,
  input  logic signed [W-1:0] filt_n,
  output logic                u_valid,
  output logic signed [W-1:0] u_out
);
  localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  function automatic logic signed [W-1:0] sadd(input logic signed [W-1:0] a,
                                               input logic signed [W-1:0] b);
    logic [W:0] s;
    s = {a[W-1], a} + {b[W-1], b};
    if (s[W] != s[W-1]) return s[W] ? MINV : MAXV;
    return s[W-1:0];
  endfunction

  function automatic logic signed [W-1:0] ssub(input logic signed [W-1:0] a,
                                               input logic signed [W-1:0] b);
    logic [W:0] s;
    s = {a[W-1], a} - {b[W-1], b};
    if (s[W] != s[W-1]) return s[W] ? MINV : MAXV;
    return s[W-1:0];
  endfunction

  pidf_phase_e phase;
  logic accept;

  pidf_seq seq_i (
    .clk(clk), .rst_n(rst_n), .init(init), .in_valid(in_valid),
    .in_ready(in_ready), .accept(accept), .phase(phase), .u_valid(u_valid)
  );

  logic signed [W-1:0] err_q, ff_q, trk_q, kp_q, ki_q, kd_q, kn_q;
  logic signed [W-1:0] filt_q, integ_q;
  logic signed [W-1:0] dt_q, fc_q, pe_q, ie_q;
  logic signed [W-1:0] mul_a, mul_b, mul_y;
  logic signed [W-1:0] sum_c, u_c, filt_c, corr_c, integ_c;

  always_comb begin
    unique case (phase)
      PH_DERIV: begin mul_a = kd_q; mul_b = err_q; end
      PH_FILT:  begin mul_a = dt_q; mul_b = kn_q;  end
      PH_PROP:  begin mul_a = kp_q; mul_b = err_q; end
      default:  begin mul_a = ki_q; mul_b = err_q; end
    endcase
  end

  pidf_mul #(.W(W), .FRAC(FRAC)) mul_i (.a(mul_a), .b(mul_b), .y(mul_y));

  always_comb begin
    sum_c   = sadd(sadd(pe_q, integ_q), fc_q);
    u_c     = sadd(ff_q, sum_c);
    filt_c  = sadd(filt_q, fc_q);
    corr_c  = ssub(ssub(trk_q, ff_q), sum_c);
    integ_c = sadd(sadd(corr_c, ie_q), integ_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= '0; ff_q <= '0; trk_q <= '0;
      kp_q <= '0; ki_q <= '0; kd_q <= '0; kn_q <= '0;
      dt_q <= '0; fc_q <= '0; pe_q <= '0; ie_q <= '0;
      filt_q <= '0; integ_q <= '0; u_out <= '0;
    end else begin
      if (accept) begin
        err_q <= ssub(setpoint, feedback);
        ff_q  <= feedfwd;
        trk_q <= track;
        kp_q  <= gain_p;
        ki_q  <= gain_i;
        kd_q  <= gain_d;
        kn_q  <= filt_n;
      end
      unique case (phase)
        PH_DERIV: dt_q <= ssub(mul_y, filt_q);
        PH_FILT:  fc_q <= mul_y;
        PH_PROP:  pe_q <= mul_y;
        PH_INTG:  ie_q <= mul_y;
        PH_FINAL: if (!init) begin
          u_out   <= u_c;
          filt_q  <= filt_c;
          integ_q <= integ_c;
        end
        default: ;
      endcase
      if (init) begin
        filt_q  <= '0;
        integ_q <= '0;
      end
    end
  end

  a_r10_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (filt_q == '0 && integ_q == '0));
  a_r11_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !u_valid |-> $stable(u_out));
  a_r7_filt_only_final: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) != PH_FINAL && !$past(init)) |-> $stable(filt_q));
endmodule

// File: tb/pidf_step_tb.sv
module pidf_step_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init = 1'b0, in_valid = 1'b0, in_ready, u_valid;
  logic signed [31:0] setpoint = 0, feedback = 0, feedfwd = 0, track = 0;
  logic signed [31:0] gain_p = 0, gain_i = 0, gain_d = 0, filt_n = 0, u_out;

  int n_chk = 0, n_fail = 0;
  int m_filt = 0, m_integ = 0;

  always #10 clk = ~clk;

  pidf_step dut_i (
    .clk(clk), .rst_n(rst_n), .init(init), .in_valid(in_valid), .in_ready(in_ready),
    .setpoint(setpoint), .feedback(feedback), .feedfwd(feedfwd), .track(track),
    .gain_p(gain_p), .gain_i(gain_i), .gain_d(gain_d), .filt_n(filt_n),
    .u_valid(u_valid), .u_out(u_out)
  );

  function automatic int clampv(longint v);
    if (v > 64'sd2147483647) return 32'h7fffffff;
    if (v < -64'sd2147483648) return 32'h80000000;
    return int'(v);
  endfunction
  function automatic int f_add(int a, int b);
    return clampv(longint'(a) + longint'(b));
  endfunction
  function automatic int f_sub(int a, int b);
    return clampv(longint'(a) - longint'(b));
  endfunction
  function automatic int f_mul(int a, int b);
    longint p;
    p = longint'(a) * longint'(b);
    return clampv((p + 64'sd32768) >>> 16);
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int rsig(int bits);
    int v;
    v = int'($urandom);
    return v >>> (32 - bits);
  endfunction

  task automatic run_step(int r, int m, int f, int t, int kp, int ki, int kd, int kn, bit noisy);
    int e, dt, fc, pe, ie, s, u, c;
    e  = f_sub(r, m);
    dt = f_sub(f_mul(kd, e), m_filt);
    fc = f_mul(dt, kn);
    pe = f_mul(kp, e);
    ie = f_mul(ki, e);
    s  = f_add(f_add(pe, m_integ), fc);
    u  = f_add(f, s);
    c  = f_sub(f_sub(t, f), s);
    @(negedge clk);
    setpoint = r; feedback = m; feedfwd = f; track = t;
    gain_p = kp; gain_i = ki; gain_d = kd; filt_n = kn;
    in_valid = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b0, "R2 ready low while busy", in_ready, 0);
    in_valid = noisy;
    if (noisy) begin
      setpoint = rsig(30); feedback = rsig(30); feedfwd = rsig(30); track = rsig(30);
      gain_p = rsig(24); gain_i = rsig(24); gain_d = rsig(24); filt_n = rsig(24);
    end
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      chk(u_valid == 1'b0, "R3 no early strobe", u_valid, 0);
      if (k == 3) in_valid = 1'b0;
    end
    @(negedge clk);
    chk(u_valid == 1'b1, "R3 strobe on fifth edge", u_valid, 1);
    chk(u_out == u, "R6 output value", u_out, u);
    @(negedge clk);
    chk(u_valid == 1'b0, "R3 strobe one cycle", u_valid, 0);
    chk(u_out == u, "R11 output held", u_out, u);
    chk(in_ready == 1'b1, "R2 ready after result", in_ready, 1);
    m_filt  = f_add(m_filt, fc);
    m_integ = f_add(f_add(c, ie), m_integ);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int held;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
    chk(u_valid == 1'b0, "R1 strobe low after reset", u_valid, 0);
    chk(u_out == 0, "R1 output zero after reset", u_out, 0);

    // R5 R6 R7 R8: first step with zero state, kp = 1.0, error 1.5
    run_step(32'h20000, 32'h8000, 32'h10000, 32'h30000, 32'h10000, 32'h4000, 32'h8000, 32'h20000, 1'b0);
    // R9: same inputs again, result now depends on accumulated state
    run_step(32'h20000, 32'h8000, 32'h10000, 32'h30000, 32'h10000, 32'h4000, 32'h8000, 32'h20000, 1'b0);

    // R4 rounding ties: raw 1 times +/-0x8000
    init = 1'b1; @(negedge clk); init = 1'b0; m_filt = 0; m_integ = 0;
    run_step(32'h8000, 0, 0, 0, 1, 0, 0, 0, 1'b0);
    chk(u_out == 1, "R4 positive tie rounds up", u_out, 1);
    init = 1'b1; @(negedge clk); init = 1'b0; m_filt = 0; m_integ = 0;
    run_step(-32'sh8000, 0, 0, 0, 1, 0, 0, 0, 1'b0);
    chk(u_out == 0, "R4 negative tie rounds toward plus", u_out, 0);

    // R4 saturation: error and output clamp
    run_step(32'h7fffffff, 32'h80000000, 32'h10000, 0, 32'h20000, 32'h10000, 32'h10000, 32'h10000, 1'b0);
    chk(u_out == 32'h7fffffff, "R4 output saturates high", u_out, 32'h7fffffff);
    run_step(32'h80000000, 32'h7fffffff, -32'sh10000, 0, 32'h20000, 0, 0, 0, 1'b0);

    // R2: busy inputs ignored
    run_step(32'h50000, 32'h18000, 32'h2000, -32'sh4000, 32'h18000, 32'h3000, 32'h6000, 32'h8000, 1'b1);

    // R10: init in the middle of a step aborts and clears state
    held = u_out;
    @(negedge clk);
    setpoint = 32'h40000; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    init = 1'b1;
    @(negedge clk);
    init = 1'b0;
    m_filt = 0; m_integ = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(u_valid == 1'b0, "R10 no strobe after abort", u_valid, 0);
    end
    chk(u_out == held, "R11 output held after abort", u_out, held);

    // R10: init while idle blocks acceptance
    @(negedge clk);
    init = 1'b1; in_valid = 1'b1;
    #1 chk(in_ready == 1'b0, "R10 ready low during init", in_ready, 0);
    @(negedge clk);
    init = 1'b0; in_valid = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(u_valid == 1'b0, "R10 no step taken under init", u_valid, 0);
    end
    // R10 R9: next step sees cleared state
    run_step(32'h30000, 32'h10000, 0, 0, 32'h10000, 32'h10000, 32'h10000, 32'h10000, 1'b0);

    // R5 R6 R7 R8 R9: random sequences
    for (int n = 0; n < 60; n++) begin
      if (n % 20 == 19) begin
        @(negedge clk); init = 1'b1; @(negedge clk); init = 1'b0;
        m_filt = 0; m_integ = 0;
      end
      run_step(rsig(24), rsig(24), rsig(22), rsig(24), rsig(20), rsig(18), rsig(18), rsig(18), n[0]);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule